// File: doc/BRIEF.md
# ADC Conversion Clock Divider

This block turns the peripheral clock into the timing pulses that drive an ADC conversion engine. The division is a chain of three stages: a fixed divide-by-two, a programmable prescaler, and a programmable scaler. It produces a one-cycle enable each time a conversion clock would tick. Every twelfth of those enables it also raises a sample strobe, because one sample takes twelve conversion clocks. Both outputs are enables in the peripheral clock domain, so no derived clock is created.

Software sets the divider through a single 32-bit clock-control word at offset 0x0C on a simple write port. The parameter `LAYOUT` selects one of two field layouts. The legacy layout has a 15-bit prescaler in bits [31:17] and a 10-bit scaler in bits [9:0], so the conversion period is 2 × (prescaler+1) × (scaler+1) peripheral cycles. The newer layout has no prescaler and a 16-bit scaler in bits [15:0], so the period is 2 × (scaler+1). A new value is applied only when a conversion enable fires, so no period ever mixes old and new settings.

Top module: `adc_clkdiv`

## Requirements
- R1: After reset all divider fields are zero. `conv_en_o` is low in the first cycle after reset is released, high in the second, and then high every 2 cycles.
- R2: In the legacy layout (`LAYOUT` = 1), the prescaler is bits [31:17] and the scaler is bits [9:0]. `conv_en_o` pulses every 2 × (prescaler+1) × (scaler+1) clock cycles.
- R3: In the newer layout (`LAYOUT` = 0), the scaler is bits [15:0]. `conv_en_o` pulses every 2 × (scaler+1) clock cycles.
- R4: A write updates the divider only when `wr_en_i` is high and `wr_addr_i` equals 0x0C. Writes to any other address leave the conversion period unchanged.
- R5: Bits outside the fields of the selected layout have no effect on the period: bits [16:10] in the legacy layout, and bits [31:16] in the newer layout.
- R6: `conv_en_o` is never high in two consecutive cycles.
- R7: `sample_o` is high only together with `conv_en_o`, on every twelfth conversion enable counted from reset. The first `sample_o` comes with the twelfth enable after reset.
- R8: After a register write, the conversion interval already in progress completes with the old setting. Every later interval uses the new setting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Peripheral clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W | Register write byte address |
| wr_data_i | input | 32 | Register write data |
| conv_en_o | output | 1 | One-cycle conversion clock enable |
| sample_o | output | 1 | One-cycle strobe on every twelfth conversion enable |

## Verification
The bench writes a new divider value in the same cycle that a conversion enable appears. It then measures two intervals: the one in progress, which must keep the old length, and the next, which must have the new length. A design that applied fields immediately would produce a truncated or mixed-length interval. The bench also writes values with set bits outside the fields, which would show up as a far longer period if those bits leaked into a counter. It writes to neighbouring offsets, which would change the period if the address decode were loose. Finally it checks the exact cycle of the first enable after reset and the twelve-enable sample spacing, which would expose an off-by-one counter limit.

// File: rtl/adc_clkdiv_pkg.sv
package adc_clkdiv_pkg;
  localparam int unsigned CLK_CTRL_OFS    = 'h0C;
  localparam int unsigned CONV_PER_SAMPLE = 12;
  localparam int unsigned LEG_PRE_LSB     = 17;
  localparam int unsigned LEG_PRE_W       = 15;
  localparam int unsigned LEG_SCL_W       = 10;
  localparam int unsigned NEW_SCL_W       = 16;

  typedef enum logic {
    LAYOUT_NEW    = 1'b0,
    LAYOUT_LEGACY = 1'b1
  } layout_e;
endpackage

// File: rtl/adc_clkdiv_regs.sv
module adc_clkdiv_regs
  import adc_clkdiv_pkg::*;
#(
  parameter layout_e LAYOUT = LAYOUT_LEGACY,
  parameter int      ADDR_W = 8,
  parameter int      PRE_W  = LEG_PRE_W,
  parameter int      SCL_W  = LEG_SCL_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [31:0]       wr_data_i,
  output logic [PRE_W-1:0]  pre_o,
  output logic [SCL_W-1:0]  scl_o
);
  logic             hit;
  logic [SCL_W-1:0] scl_q;
  logic             unused_bits;

  assign hit         = wr_en_i && (wr_addr_i == ADDR_W'(CLK_CTRL_OFS));
  assign unused_bits = ^wr_data_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  scl_q <= '0;
    else if (hit) scl_q <= wr_data_i[SCL_W-1:0];
  end
  assign scl_o = scl_q;

  generate
    if (LAYOUT == LAYOUT_LEGACY) begin : g_pre
      logic [PRE_W-1:0] pre_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)  pre_q <= '0;
        else if (hit) pre_q <= wr_data_i[LEG_PRE_LSB +: PRE_W];
      end
      assign pre_o = pre_q;
    end else begin : g_no_pre
      assign pre_o = '0;
    end
  endgenerate
endmodule

// File: rtl/adc_clkdiv_stage.sv
module adc_clkdiv_stage #(
  parameter int           W       = 10,
  parameter logic [W-1:0] RST_LIM = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         load_i,
  input  logic [W-1:0] lim_i,
  output logic         tick_o
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] lim_q;

  assign tick_o = en_i && (cnt_q == lim_q);

  // limit reloads only at the load pulse, so a period never mixes settings
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      lim_q <= RST_LIM;
    end else begin
      if (en_i)   cnt_q <= tick_o ? '0 : cnt_q + 1'b1;
      if (load_i) lim_q <= lim_i;
    end
  end
endmodule

// File: rtl/adc_clkdiv_sample.sv
module adc_clkdiv_sample
  import adc_clkdiv_pkg::*;
#(
  parameter int N = CONV_PER_SAMPLE
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic conv_i,
  output logic sample_o
);
  localparam int CW = $clog2(N);

  logic [CW-1:0] cnt_q;

  assign sample_o = conv_i && (cnt_q == CW'(N - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (conv_i) cnt_q <= sample_o ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/adc_clkdiv.sv
module adc_clkdiv
  import adc_clkdiv_pkg::*;
#(
  parameter layout_e LAYOUT = LAYOUT_LEGACY,
  parameter int      ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [31:0]       wr_data_i,
  output logic              conv_en_o,
  output logic              sample_o
);
  localparam int PRE_W = LEG_PRE_W;
  localparam int SCL_W = (LAYOUT == LAYOUT_LEGACY) ? LEG_SCL_W : NEW_SCL_W;

  logic [PRE_W-1:0] pre_cfg;
  logic [SCL_W-1:0] scl_cfg;
  logic             half_tick;
  logic             pre_tick;

  adc_clkdiv_regs #(
    .LAYOUT(LAYOUT), .ADDR_W(ADDR_W), .PRE_W(PRE_W), .SCL_W(SCL_W)
  ) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .pre_o     (pre_cfg),
    .scl_o     (scl_cfg)
  );

  // fixed divide-by-two
  adc_clkdiv_stage #(.W(1), .RST_LIM(1'b1)) u_half (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (1'b1),
    .load_i (1'b0),
    .lim_i  (1'b1),
    .tick_o (half_tick)
  );

  generate
    if (LAYOUT == LAYOUT_LEGACY) begin : g_pre
      adc_clkdiv_stage #(.W(PRE_W)) u_pre (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .en_i   (half_tick),
        .load_i (conv_en_o),
        .lim_i  (pre_cfg),
        .tick_o (pre_tick)
      );
    end else begin : g_no_pre
      logic unused_pre;
      assign unused_pre = ^pre_cfg;
      assign pre_tick   = half_tick;
    end
  endgenerate

  adc_clkdiv_stage #(.W(SCL_W)) u_scl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (pre_tick),
    .load_i (conv_en_o),
    .lim_i  (scl_cfg),
    .tick_o (conv_en_o)
  );

  adc_clkdiv_sample #(.N(CONV_PER_SAMPLE)) u_smp (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .conv_i   (conv_en_o),
    .sample_o (sample_o)
  );
endmodule

// File: rtl/adc_clkdiv_chk.sv
module adc_clkdiv_chk #(
  parameter int ADDR_W = 8,
  parameter int PRE_W  = 15,
  parameter int SCL_W  = 10
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] wr_addr_i,
  input logic              conv_en_o,
  input logic              sample_o,
  input logic [PRE_W-1:0]  pre_cfg,
  input logic [SCL_W-1:0]  scl_cfg
);
  logic [3:0] seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        seen_q <= '0;
    else if (conv_en_o) seen_q <= sample_o ? 4'd0 : seen_q + 4'd1;
  end

  AST_CONV_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_en_o |=> !conv_en_o);  // R6
  AST_SAMPLE_WITH_CONV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_o |-> conv_en_o);  // R7
  AST_SAMPLE_DUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (conv_en_o && seen_q == 4'd11) |-> sample_o);  // R7
  AST_SAMPLE_NOT_EARLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_o |-> (seen_q == 4'd11));  // R7
  AST_OTHER_ADDR_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i != ADDR_W'('h0C)) |=> ($stable(scl_cfg) && $stable(pre_cfg)));  // R4
  AST_IDLE_HOLDS_CFG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> ($stable(scl_cfg) && $stable(pre_cfg)));  // R4
endmodule

bind adc_clkdiv adc_clkdiv_chk #(.ADDR_W(ADDR_W), .PRE_W(PRE_W), .SCL_W(SCL_W)) u_chk (.*);

// File: tb/adc_clkdiv_tb_top.sv
`timescale 1ns/1ps
module adc_clkdiv_tb_top;
  import adc_clkdiv_pkg::*;

  typedef struct packed {
    logic        leg;
    logic [31:0] val;
  } vec_t;

  localparam int NV = 10;
  // legacy: 0x00010400 has only out-of-field bits 16,10 set (R5)
  // newer: 0x00010002 has out-of-field bit 16 set (R5)
  localparam vec_t VECS [NV] = '{
    '{1'b1, 32'h0000_0004}, '{1'b1, 32'h0002_0000}, '{1'b1, 32'h0006_0003},
    '{1'b1, 32'h0001_0400}, '{1'b1, 32'h0004_0005}, '{1'b0, 32'h0000_0007},
    '{1'b0, 32'h0001_0002}, '{1'b0, 32'h0000_001F}, '{1'b0, 32'h0000_0000},
    '{1'b1, 32'h0000_0009}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [7:0]  wr_addr;
  logic [31:0] wr_data;
  logic        conv_l, smp_l, conv_n, smp_n;
  int          cyc = 0;
  int          n_chk = 0;
  int          n_fail = 0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  adc_clkdiv #(.LAYOUT(LAYOUT_LEGACY)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .conv_en_o(conv_l), .sample_o(smp_l)
  );

  adc_clkdiv #(.LAYOUT(LAYOUT_NEW)) dut_new_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .conv_en_o(conv_n), .sample_o(smp_n)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int per(input logic leg, input logic [31:0] v);
    if (leg) return 2 * (int'(v[31:17]) + 1) * (int'(v[9:0]) + 1);
    return 2 * (int'(v[15:0]) + 1);
  endfunction

  function automatic logic cv(input logic leg);
    return leg ? conv_l : conv_n;
  endfunction

  function automatic logic sv(input logic leg);
    return leg ? smp_l : smp_n;
  endfunction

  task automatic wait_conv(input logic leg, output int t);
    do @(negedge clk); while (!cv(leg));
    t = cyc;
  endtask

  task automatic wait_smp(input logic leg, output int t);
    do @(negedge clk); while (!sv(leg));
    t = cyc;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog (all requirements): actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    int rel, t, t0, ta, tb, s1, s2;
    logic [31:0] last;
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    rel = cyc;
    check("R1 conv_en low at release", int'(conv_l), 0);
    check("R1 sample low at release", int'(smp_l), 0);
    for (int k = 1; k <= 12; k++) begin
      wait_conv(1'b1, t);
      check("R1 enable cycle after reset", t - rel, 2 * k - 1);
      check("R7 sample on twelfth enable only", int'(smp_l), (k == 12) ? 1 : 0);
    end

    // vector table: write on an enable cycle, old interval then new interval
    last = '0;
    for (int i = 0; i < NV; i++) begin
      wait_conv(VECS[i].leg, t0);
      wr(8'h0C, VECS[i].val);
      wait_conv(VECS[i].leg, ta);
      wait_conv(VECS[i].leg, tb);
      check("R8 interval in progress keeps old setting", ta - t0, per(VECS[i].leg, last));
      check(VECS[i].leg ? "R2 R5 legacy period" : "R3 R5 newer period",
            tb - ta, per(VECS[i].leg, VECS[i].val));
      @(negedge clk);
      check("R6 enable single cycle", int'(cv(VECS[i].leg)), 0);
      last = VECS[i].val;
    end

    // other offsets must not change the divider
    wr(8'h0C, 32'h0000_0004);
    wait_conv(1'b1, t); wait_conv(1'b1, t);
    wr(8'h08, 32'h0000_0001);
    wr(8'h1C, 32'h0000_0001);
    wr(8'h8C, 32'h0000_0001);
    wait_conv(1'b1, ta); wait_conv(1'b1, tb);
    check("R4 legacy period after foreign writes", tb - ta, 10);
    wait_conv(1'b0, ta); wait_conv(1'b0, tb);
    check("R4 newer period after foreign writes", tb - ta, 10);

    // sample spacing at period 10
    wait_smp(1'b1, s1); wait_smp(1'b1, s2);
    check("R7 legacy sample spacing", s2 - s1, 120);
    wait_smp(1'b0, s1); wait_smp(1'b0, s2);
    check("R7 newer sample spacing", s2 - s1, 120);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule